// File: doc/BRIEF.md
# Sign-Sign LMS Sampling-Skew Calibrator

This block estimates, in the background, the sampling-clock skew of each channel of a time-interleaved ADC, and it drives a delay-trim code for each channel. The reference channel samples at a rate slightly different from the interleaved channels, so each cycle it lines up with one interleaved channel in turn. Each accepted cycle carries the result of the reference channel, the result of the aligned interleaved channel, and the channel index. It also carries two candidate derivative samples: one from a dedicated bandwidth-shifted channel and one from the neighbouring interleaved channel, taken one sample period earlier.

For every channel the block keeps an offset estimate. It removes that estimate from the reference-minus-channel difference to form a zero-mean error. It also keeps a fixed-point skew accumulator. The accumulator takes one fine step whose direction is the product of the error sign and the derivative sign. The step is skipped whenever the derivative magnitude falls below a programmable dead-zone threshold. The update needs no multiplier. The trim code is the accumulator with its fractional bits dropped, so the step size µ is one fractional LSB. In neighbour mode, a zone-parity input inverts the update direction in odd Nyquist zones.

Top module: `tskew_sslms_cal`

## Requirements
- R1: Synchronous reset (rst_n low at a clock edge) sets every skew accumulator to mid-scale 2^(ACC_W-1), so every trim code reads 2^(TRIM_W-1). It also clears every offset estimate to zero.
- R2: The error for an accepted sample is ref_smp − ti_smp − (offset accumulator of the addressed channel arithmetically shifted right by OS_SHIFT).
- R3: With d_src = 0 the derivative proxy is ref_smp − aux_smp.
- R4: With d_src = 1 the derivative proxy is ti_smp − nbr_smp.
- R5: When |D| ≥ dz_thresh, the addressed skew accumulator moves by +1 when the error and D have the same nonzero sign, and by −1 when their signs differ. It does not move when either value is zero.
- R6: When |D| < dz_thresh, the skew accumulator does not change.
- R7: With d_src = 1 and zone_par = 1 the skew step direction is inverted. With d_src = 0, zone_par has no effect.
- R8: The trim code of channel c occupies bits [c*TRIM_W +: TRIM_W] of trim_codes and equals accumulator[ACC_W-1:FRAC]. It shows a new value one clock edge after the sample is accepted.
- R9: Skew accumulators saturate at 0 and at 2^ACC_W − 1 and never wrap.
- R10: A sample is accepted only when smp_valid = 1 and cal_en = 1. Otherwise no accumulator or offset estimate changes.
- R11: An accepted sample moves the offset accumulator of its channel by the sign of the error (+1, −1 or 0), whatever the dead zone does. All other channels keep their offset and skew state.
- R12: A sample whose smp_chan is M or greater is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_en | input | 1 | Enables all updates |
| smp_valid | input | 1 | Sample pair valid |
| smp_chan | input | CW | Index of the interleaved channel aligned with the reference |
| ref_smp | input | DW | Reference channel result, signed |
| ti_smp | input | DW | Interleaved channel result, signed |
| aux_smp | input | DW | Bandwidth-shifted channel result, signed |
| nbr_smp | input | DW | Neighbour channel result one period earlier, signed |
| d_src | input | 1 | Derivative source: 0 dedicated, 1 neighbour |
| zone_par | input | 1 | Odd Nyquist zone flag |
| dz_thresh | input | DW | Dead-zone threshold on abs(D), unsigned |
| trim_codes | output | M*TRIM_W | Packed per-channel delay-trim codes |

## Verification
Assertions check on every cycle that each accumulator moves by at most one step and never wraps at either end. They also check that channels other than the addressed one hold, that trims hold while updates are disabled, and that a dead-zone sample leaves every trim unchanged. Only the bench scenarios can show that the step direction is correct, because that depends on the error and derivative arithmetic, the offset loop history, the source selection and the zone inversion. The bench shows this by comparing every trim, after every sample, against an arithmetic model over long deterministic sweeps.

// File: rtl/tskew_sslms_pkg.sv
`timescale 1ns/1ps
package tskew_sslms_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_UP   = 2'b01,
        STEP_DOWN = 2'b10
    } step_dir_e;
endpackage

// File: rtl/tskew_dir_logic.sv
`timescale 1ns/1ps
module tskew_dir_logic
    import tskew_sslms_pkg::*;
#(
    parameter int DW  = 12,
    parameter int OFW = 18
) (
    input  logic signed [DW-1:0]  ref_smp,
    input  logic signed [DW-1:0]  ti_smp,
    input  logic signed [DW-1:0]  aux_smp,
    input  logic signed [DW-1:0]  nbr_smp,
    input  logic signed [OFW-1:0] off_int,
    input  logic                  d_src,
    input  logic                  zone_par,
    input  logic [DW-1:0]         dz_thresh,
    output step_dir_e             ofs_dir,
    output step_dir_e             skew_dir,
    output logic                  dead
);
    localparam int EW = OFW + 2;

    logic signed [EW-1:0] err_w;
    logic signed [DW:0]   d_ded_w, d_nbr_w, d_w;
    logic [DW+1:0]        d_ext_w, d_abs_w;
    logic e_pos, e_neg, d_pos, d_neg, same_w, diff_w, inv_w;

    always_comb begin
        err_w   = EW'(ref_smp) - EW'(ti_smp) - EW'(off_int);
        d_ded_w = (DW+1)'(ref_smp) - (DW+1)'(aux_smp);
        d_nbr_w = (DW+1)'(ti_smp) - (DW+1)'(nbr_smp);
        d_w     = d_src ? d_nbr_w : d_ded_w;
        d_ext_w = {d_w[DW], d_w};
        d_abs_w = d_w[DW] ? (~d_ext_w + 1'b1) : d_ext_w;
        dead    = d_abs_w < {2'b00, dz_thresh};

        e_neg = err_w[EW-1];
        e_pos = !err_w[EW-1] && (err_w != '0);
        d_neg = d_w[DW];
        d_pos = !d_w[DW] && (d_w != '0);

        ofs_dir = e_pos ? STEP_UP : (e_neg ? STEP_DOWN : STEP_HOLD);

        same_w = (e_pos && d_pos) || (e_neg && d_neg);
        diff_w = (e_pos && d_neg) || (e_neg && d_pos);
        inv_w  = d_src && zone_par;
        if (dead || !(same_w || diff_w))
            skew_dir = STEP_HOLD;
        else if (same_w ^ inv_w)
            skew_dir = STEP_UP;
        else
            skew_dir = STEP_DOWN;
    end
endmodule

// File: rtl/tskew_ofs_bank.sv
`timescale 1ns/1ps
module tskew_ofs_bank
    import tskew_sslms_pkg::*;
#(
    parameter int M        = 24,
    parameter int CW       = 5,
    parameter int OFW      = 18,
    parameter int OS_SHIFT = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  upd,
    input  logic [CW-1:0]         chan,
    input  step_dir_e             dir,
    output logic signed [OFW-1:0] off_int
);
    localparam logic [OFW-1:0] OMAX = {1'b0, {(OFW-1){1'b1}}};
    localparam logic [OFW-1:0] OMIN = {1'b1, {(OFW-1){1'b0}}};

    typedef struct packed {
        logic [M-1:0][OFW-1:0] acc;
    } ofs_state_t;

    ofs_state_t st_d, st_q;
    logic [OFW-1:0] sel_w;

    always_comb begin
        st_d  = st_q;
        sel_w = '0;
        for (int i = 0; i < M; i++) begin
            if (chan == i[CW-1:0]) sel_w = st_q.acc[i];
            if (upd && chan == i[CW-1:0]) begin
                if (dir == STEP_UP && st_q.acc[i] != OMAX)
                    st_d.acc[i] = st_q.acc[i] + 1'b1;
                else if (dir == STEP_DOWN && st_q.acc[i] != OMIN)
                    st_d.acc[i] = st_q.acc[i] - 1'b1;
            end
        end
        off_int = $signed(sel_w) >>> OS_SHIFT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.acc <= '0;
        else        st_q     <= st_d;
    end

    for (genvar g = 0; g < M; g++) begin : g_chk
        assert_ofs_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.acc[g] == $past(st_q.acc[g])) ||
            (st_q.acc[g] == $past(st_q.acc[g]) + 1'b1) ||
            (st_q.acc[g] == $past(st_q.acc[g]) - 1'b1));
        assert_ofs_other_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !(upd && chan == g[CW-1:0]) |=> $stable(st_q.acc[g]));
    end
endmodule

// File: rtl/tskew_acc_bank.sv
`timescale 1ns/1ps
module tskew_acc_bank
    import tskew_sslms_pkg::*;
#(
    parameter int M      = 24,
    parameter int CW     = 5,
    parameter int TRIM_W = 6,
    parameter int FRAC   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  upd,
    input  logic [CW-1:0]         chan,
    input  step_dir_e             dir,
    output logic [M*TRIM_W-1:0]   trim_codes
);
    localparam int ACC_W = TRIM_W + FRAC;
    localparam logic [ACC_W-1:0] AMAX = {ACC_W{1'b1}};
    localparam logic [ACC_W-1:0] AMID = {1'b1, {(ACC_W-1){1'b0}}};

    typedef struct packed {
        logic [M-1:0][ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < M; i++) begin
            if (upd && chan == i[CW-1:0]) begin
                if (dir == STEP_UP && st_q.acc[i] != AMAX)
                    st_d.acc[i] = st_q.acc[i] + 1'b1;
                else if (dir == STEP_DOWN && st_q.acc[i] != '0)
                    st_d.acc[i] = st_q.acc[i] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.acc <= {M{AMID}};
        else        st_q     <= st_d;
    end

    for (genvar g = 0; g < M; g++) begin : g_trim
        assign trim_codes[g*TRIM_W +: TRIM_W] = st_q.acc[g][ACC_W-1:FRAC];

        assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.acc[g] == $past(st_q.acc[g])) ||
            (st_q.acc[g] == $past(st_q.acc[g]) + 1'b1) ||
            (st_q.acc[g] == $past(st_q.acc[g]) - 1'b1));
        assert_no_wrap_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.acc[g] == AMAX) |=> (st_q.acc[g] != '0));
        assert_no_wrap_bottom_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.acc[g] == '0) |=> (st_q.acc[g] != AMAX));
        assert_other_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !(upd && chan == g[CW-1:0]) |=> $stable(st_q.acc[g]));
    end
endmodule

// File: rtl/tskew_sslms_cal.sv
`timescale 1ns/1ps
module tskew_sslms_cal
    import tskew_sslms_pkg::*;
#(
    parameter int M        = 24,
    parameter int DW       = 12,
    parameter int TRIM_W   = 6,
    parameter int FRAC     = 4,
    parameter int OS_SHIFT = 4,
    parameter int CW       = (M > 1) ? $clog2(M + 1) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cal_en,
    input  logic                 smp_valid,
    input  logic [CW-1:0]        smp_chan,
    input  logic signed [DW-1:0] ref_smp,
    input  logic signed [DW-1:0] ti_smp,
    input  logic signed [DW-1:0] aux_smp,
    input  logic signed [DW-1:0] nbr_smp,
    input  logic                 d_src,
    input  logic                 zone_par,
    input  logic [DW-1:0]        dz_thresh,
    output logic [M*TRIM_W-1:0]  trim_codes
);
    localparam int OFW = DW + OS_SHIFT + 2;
    localparam logic [CW:0] M_L = (CW+1)'(M);

    logic                  accept_w, dead_w;
    logic signed [OFW-1:0] off_int_w;
    step_dir_e             ofs_dir_w, skew_dir_w;

    assign accept_w = smp_valid && cal_en && ({1'b0, smp_chan} < M_L);

    tskew_dir_logic #(.DW(DW), .OFW(OFW)) dir_i (
        .ref_smp(ref_smp), .ti_smp(ti_smp), .aux_smp(aux_smp), .nbr_smp(nbr_smp),
        .off_int(off_int_w), .d_src(d_src), .zone_par(zone_par), .dz_thresh(dz_thresh),
        .ofs_dir(ofs_dir_w), .skew_dir(skew_dir_w), .dead(dead_w)
    );

    tskew_ofs_bank #(.M(M), .CW(CW), .OFW(OFW), .OS_SHIFT(OS_SHIFT)) ofs_i (
        .clk(clk), .rst_n(rst_n), .upd(accept_w), .chan(smp_chan),
        .dir(ofs_dir_w), .off_int(off_int_w)
    );

    tskew_acc_bank #(.M(M), .CW(CW), .TRIM_W(TRIM_W), .FRAC(FRAC)) acc_i (
        .clk(clk), .rst_n(rst_n), .upd(accept_w), .chan(smp_chan),
        .dir(skew_dir_w), .trim_codes(trim_codes)
    );

    assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_valid && cal_en) |=> $stable(trim_codes));
    assert_dead_zone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dead_w |=> $stable(trim_codes));
    assert_bad_chan_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, smp_chan} >= M_L) |=> $stable(trim_codes));
endmodule

// File: tb/tskew_sslms_cal_tb_top.sv
`timescale 1ns/1ps
module tskew_sslms_cal_tb_top;
    localparam int M = 5, DW = 8, TW = 4, FR = 2, OSS = 2, CW = 3;
    localparam int AMAXI = (1 << (TW + FR)) - 1;

    logic clk = 1'b0, rst_n = 1'b0, cal_en = 1'b0, smp_valid = 1'b0;
    logic [CW-1:0] smp_chan = '0;
    logic signed [DW-1:0] ref_smp = '0, ti_smp = '0, aux_smp = '0, nbr_smp = '0;
    logic d_src = 1'b0, zone_par = 1'b0;
    logic [DW-1:0] dz_thresh = '0;
    logic [M*TW-1:0] trim_codes;

    int acc_m [M];
    int off_m [M];
    int n_chk = 0, n_fail = 0, seed = 12345;
    bit done = 0;

    always #2.5 clk = ~clk;

    tskew_sslms_cal #(.M(M), .DW(DW), .TRIM_W(TW), .FRAC(FR), .OS_SHIFT(OSS), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .smp_valid(smp_valid), .smp_chan(smp_chan),
        .ref_smp(ref_smp), .ti_smp(ti_smp), .aux_smp(aux_smp), .nbr_smp(nbr_smp),
        .d_src(d_src), .zone_par(zone_par), .dz_thresh(dz_thresh), .trim_codes(trim_codes)
    );

    function automatic int sgn(int x);
        return (x > 0) ? 1 : ((x < 0) ? -1 : 0);
    endfunction

    function automatic int rnd(int lo, int hi);
        seed = seed * 1103515245 + 12345;
        return lo + (((seed >>> 8) & 32'h7fff) % (hi - lo + 1));
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int c = 0; c < M; c++) begin
            int got = int'(trim_codes[c*TW +: TW]);
            check(got == (acc_m[c] >> FR), req, got, acc_m[c] >> FR);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < M; c++) begin
            acc_m[c] = 1 << (TW + FR - 1);
            off_m[c] = 0;
        end
    endtask

    // Drive one sample at a falling edge; it is accepted at the next rising edge,
    // the trim is compared at the following falling edge (R8 latency).
    task automatic step(int ch, int r, int t, int a, int n, bit src, bit zp, int thr,
                        bit en, bit vld, string req);
        int e, d, s;
        smp_chan = ch[CW-1:0]; ref_smp = r[DW-1:0]; ti_smp = t[DW-1:0];
        aux_smp = a[DW-1:0]; nbr_smp = n[DW-1:0]; d_src = src; zone_par = zp;
        dz_thresh = thr[DW-1:0]; cal_en = en; smp_valid = vld;
        if (en && vld && ch < M) begin
            e = r - t - (off_m[ch] >>> OSS);
            d = src ? (t - n) : (r - a);
            off_m[ch] += sgn(e);
            if ((d < 0 ? -d : d) >= thr) begin
                s = sgn(e) * sgn(d);
                if (src && zp) s = -s;
                acc_m[ch] += s;
                if (acc_m[ch] > AMAXI) acc_m[ch] = AMAXI;
                if (acc_m[ch] < 0) acc_m[ch] = 0;
            end
        end
        @(negedge clk);
        check_all(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: mid-scale trims after reset
        for (int c = 0; c < M; c++)
            check(int'(trim_codes[c*TW +: TW]) == 8, "R1", int'(trim_codes[c*TW +: TW]), 8);

        // R3 R5 R2 R8: dedicated-source sweep over all channels
        for (int k = 0; k < 600; k++)
            step(k % M, rnd(-100, 100), rnd(-100, 100), rnd(-100, 100), rnd(-100, 100),
                 1'b0, 1'b0, rnd(0, 20), 1'b1, 1'b1, "R3_R5_R2_R8");

        // R6: derivative inside dead zone, error nonzero
        for (int k = 0; k < 100; k++) begin
            int r = rnd(-100, 100);
            step(k % M, r, rnd(-100, 100), r - rnd(-3, 3), 0, 1'b0, 1'b0, 8, 1'b1, 1'b1, "R6");
        end

        // R4: neighbour source, even zone
        for (int k = 0; k < 400; k++)
            step(k % M, rnd(-100, 100), rnd(-100, 100), rnd(-100, 100), rnd(-100, 100),
                 1'b1, 1'b0, rnd(0, 20), 1'b1, 1'b1, "R4");
        // R7: neighbour source, odd zone inverts; dedicated source ignores zone
        for (int k = 0; k < 400; k++)
            step(k % M, rnd(-100, 100), rnd(-100, 100), rnd(-100, 100), rnd(-100, 100),
                 k[0], 1'b1, rnd(0, 20), 1'b1, 1'b1, "R7");

        // R10: updates disabled or sample not valid
        for (int k = 0; k < 60; k++)
            step(k % M, rnd(-100, 100), rnd(-100, 100), rnd(-100, 100), rnd(-100, 100),
                 1'b0, 1'b0, 0, k[0], ~k[0], "R10");

        // R12: out-of-range channel index
        for (int k = 0; k < 30; k++)
            step(M + (k % 3), 90, -90, -90, 0, 1'b0, 1'b0, 0, 1'b1, 1'b1, "R12");

        // R9 R11: drive channel 2 to the top, then to the bottom
        for (int k = 0; k < 80; k++)
            step(2, k[0] ? -60 : 60, k[0] ? -10 : 10, 0, 0, 1'b0, 1'b0, 1, 1'b1, 1'b1, "R9_R11");
        check(int'(trim_codes[2*TW +: TW]) == 15, "R9", int'(trim_codes[2*TW +: TW]), 15);
        for (int k = 0; k < 100; k++)
            step(2, k[0] ? -60 : 60, k[0] ? -10 : 10, k[0] ? -120 : 120, 0,
                 1'b0, 1'b0, 1, 1'b1, 1'b1, "R9_R11");
        check(int'(trim_codes[2*TW +: TW]) == 0, "R9", int'(trim_codes[2*TW +: TW]), 0);

        // R1: reset again mid-run
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check_all("R1");
        for (int k = 0; k < 100; k++)
            step(k % M, rnd(-100, 100), rnd(-100, 100), rnd(-100, 100), rnd(-100, 100),
                 1'b0, 1'b0, 4, 1'b1, 1'b1, "R1_R5");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule